// File: doc/BRIEF.md
# Keyboard Matrix Scanner with Key Queue

This block walks the rows of a key matrix of up to 64 switches, eight rows by eight columns. It drives one row at a time and reads eight active-low column lines back. A switch counts as closed only when it has been seen closed on two full passes in a row. It is then turned into an 8-bit key code and queued in an eight-entry first-in first-out buffer. The levels of a shift input and a control input at the moment of acceptance are stored in the same code.

The host watches an interrupt line that is high while the queue holds codes. It pulls one code per read strobe. The interrupt drops after every read and comes back on the following cycle if codes remain. A code that arrives while eight are already queued is lost and sets a sticky overrun flag, which only a dedicated clear input resets. The row output can be a plain binary row number or, for external matrices without a decoder, a one-of-four pattern. In the one-of-four case only rows 0 to 3 are walked.

Top module: `kbs_keyscan`

## Requirements
- R1: Each row position is held for exactly STEP_CLKS clocks, then the position advances by one. It wraps to 0 after row 7 in binary mode and after row 3 in one-of-four mode.
- R2: With `scan_decoded_i` = 0, `scan_o` = {1'b0, row[2:0]}. With `scan_decoded_i` = 1, `scan_o` has exactly one bit set, bit number row[1:0]. The output follows a mode change on the next clock.
- R3: A key at (row, col) is closed when `ret_n_i[col]` is 0 during the last clock of that row's time slot.
- R4: A closure is accepted only when it is seen closed on two consecutive passes over its row. A closure seen on one pass only produces no code.
- R5: A key held down for any number of passes yields one code. It can be entered again only after one pass has seen it open.
- R6: Key code bit 7 = `ctrl_i`, bit 6 = `shift_i`, bits 5:3 = row, bits 2:0 = column, with `ctrl_i` and `shift_i` sampled when the key is accepted.
- R7: The queue holds up to FIFO_DEPTH (8) codes, and the host reads them in order of acceptance. `rd_data_o` shows the oldest code from the clock after a `rd_stb_i` cycle.
- R8: A read strobe while the queue is empty leaves `rd_data_o` and the queue unchanged.
- R9: `irq_o` is 1 whenever the queue is non-empty, except in the cycle right after any read strobe, when it is 0. It returns to 1 the next cycle if codes remain.
- R10: A code accepted while the queue is full is dropped and sets `overrun_o`. `overrun_o` stays 1 until `ovr_clr_i` is pulsed, and a fresh overrun wins over a clear in the same cycle.
- R11: After reset, `irq_o`, `overrun_o`, `scan_o` and `rd_data_o` are 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_decoded_i | input | 1 | 0: binary row number, 1: one-of-four row lines |
| ret_n_i | input | 8 | Active-low column return lines |
| shift_i | input | 1 | Shift level stored with each code |
| ctrl_i | input | 1 | Control level stored with each code |
| rd_stb_i | input | 1 | Read strobe, one code per high cycle |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| scan_o | output | 4 | Row drive, binary or one-of-four |
| rd_data_o | output | 8 | Last code read from the queue |
| irq_o | output | 1 | Queue holds unread codes |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The properties assume that STEP_CLKS exceeds the column count, so the column walker finishes before the next row sample. They also assume that the return lines reflect the matrix for the row currently shown on `scan_o`. The bench keeps within this by modelling the matrix as a pure function of `scan_o` and a pressed-key vector. It changes keys and the shift and control levels only while no sample of that key's row can observe a half-changed state. Every key is pressed and held for at least three passes, released for two, and read back before the next key. A short press is held for less than one pass, so it can be sampled at most once.

// File: rtl/kbs_pkg.sv
package kbs_pkg;
  localparam int ROW_W     = 3;
  localparam int COL_W     = 3;
  localparam int NUM_ROWS  = 1 << ROW_W;
  localparam int NUM_COLS  = 1 << COL_W;
  localparam int DEC_SEL_W = 2;
  localparam int DEC_LINES = 1 << DEC_SEL_W;
  localparam int SCAN_W    = (DEC_LINES > ROW_W) ? DEC_LINES : ROW_W;
  localparam int CODE_W    = 2 + ROW_W + COL_W;

  typedef struct packed {
    logic             ctrl;
    logic             shift;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } key_code_t;
endpackage

// File: rtl/kbs_scan_timer.sv
module kbs_scan_timer
  import kbs_pkg::*;
#(
  parameter int STEP_CLKS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_dec_i,
  output logic [ROW_W-1:0]  row_o,
  output logic              sample_o,
  output logic [SCAN_W-1:0] scan_o
);
  localparam int DIV_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;

  logic [DIV_W-1:0]  div_q;
  logic [ROW_W-1:0]  row_q, row_d;
  logic              last, wrap;
  logic [SCAN_W-1:0] onehot_d, scan_d;

  always_comb begin
    last  = (div_q == DIV_W'(STEP_CLKS - 1));
    wrap  = mode_dec_i ? (row_q >= ROW_W'(DEC_LINES - 1))
                       : (row_q == ROW_W'(NUM_ROWS - 1));
    row_d = row_q;
    if (last) row_d = wrap ? '0 : row_q + ROW_W'(1);
  end

  // one-of-four line decode of the next row
  for (genvar i = 0; i < SCAN_W; i++) begin : g_dec
    if (i < DEC_LINES) begin : g_line
      assign onehot_d[i] = (row_d[DEC_SEL_W-1:0] == DEC_SEL_W'(i));
    end else begin : g_pad
      assign onehot_d[i] = 1'b0;
    end
  end

  assign scan_d = mode_dec_i ? onehot_d : SCAN_W'(row_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      row_q  <= '0;
      scan_o <= '0;
    end else begin
      div_q  <= last ? '0 : div_q + DIV_W'(1);
      row_q  <= row_d;
      scan_o <= scan_d;
    end
  end

  assign row_o    = row_q;
  assign sample_o = last;
endmodule

// File: rtl/kbs_debounce.sv
module kbs_debounce
  import kbs_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                sample_i,
  input  logic [ROW_W-1:0]    row_i,
  input  logic [NUM_COLS-1:0] ret_n_i,
  input  logic                shift_i,
  input  logic                ctrl_i,
  output logic                push_o,
  output key_code_t           code_o
);
  logic [NUM_COLS-1:0] lat_q;
  logic [ROW_W-1:0]    lrow_q;
  logic [COL_W-1:0]    col_q;
  logic                busy_q;
  logic [NUM_COLS-1:0] seen_q [NUM_ROWS];
  logic [NUM_COLS-1:0] done_q [NUM_ROWS];
  logic                closed, was_seen, was_done, accept;

  always_comb begin
    closed   = lat_q[col_q];
    was_seen = seen_q[lrow_q][col_q];
    was_done = done_q[lrow_q][col_q];
    accept   = busy_q && closed && was_seen && !was_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '0;
      lrow_q <= '0;
      col_q  <= '0;
      busy_q <= 1'b0;
      push_o <= 1'b0;
      code_o <= '0;
      for (int r = 0; r < NUM_ROWS; r++) begin
        seen_q[r] <= '0;
        done_q[r] <= '0;
      end
    end else begin
      push_o <= accept;
      if (accept) begin
        code_o.ctrl  <= ctrl_i;
        code_o.shift <= shift_i;
        code_o.row   <= lrow_q;
        code_o.col   <= col_q;
      end
      if (sample_i) begin
        lat_q  <= ~ret_n_i;
        lrow_q <= row_i;
        col_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        seen_q[lrow_q][col_q] <= closed;
        done_q[lrow_q][col_q] <= closed && (was_seen || was_done);
        col_q <= col_q + COL_W'(1);
        if (col_q == COL_W'(NUM_COLS - 1)) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kbs_key_fifo.sv
module kbs_key_fifo
  import kbs_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             push_i,
  input  logic [CODE_W-1:0]                din_i,
  input  logic                             rd_i,
  input  logic                             ovr_clr_i,
  output logic [CODE_W-1:0]                rd_data_o,
  output logic                             irq_o,
  output logic                             ovr_o,
  output logic [$clog2(DEPTH+1)-1:0]       count_o
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CODE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              full, push_ok, rd_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    full    = (cnt_q == CNT_W'(DEPTH));
    push_ok = push_i && !full;
    rd_ok   = rd_i && (cnt_q != '0);
    case ({push_ok, rd_ok})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  // storage array without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt_q     <= '0;
      rd_data_o <= '0;
      irq_o     <= 1'b0;
      ovr_o     <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (rd_ok) begin
        rd_ptr    <= ptr_inc(rd_ptr);
        rd_data_o <= mem[rd_ptr];
      end
      cnt_q <= cnt_d;
      irq_o <= rd_i ? 1'b0 : (cnt_d != '0);
      if (push_i && full)  ovr_o <= 1'b1;
      else if (ovr_clr_i)  ovr_o <= 1'b0;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/kbs_keyscan.sv
module kbs_keyscan
  import kbs_pkg::*;
#(
  parameter int STEP_CLKS  = 12,  // must exceed NUM_COLS
  parameter int FIFO_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scan_decoded_i,
  input  logic [NUM_COLS-1:0] ret_n_i,
  input  logic                shift_i,
  input  logic                ctrl_i,
  input  logic                rd_stb_i,
  input  logic                ovr_clr_i,
  output logic [SCAN_W-1:0]   scan_o,
  output logic [CODE_W-1:0]   rd_data_o,
  output logic                irq_o,
  output logic                overrun_o
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [ROW_W-1:0] scan_row;
  logic             row_sample;
  logic             key_push;
  key_code_t        key_code;
  logic [CNT_W-1:0] fifo_cnt;

  kbs_scan_timer #(.STEP_CLKS(STEP_CLKS)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .mode_dec_i (scan_decoded_i),
    .row_o      (scan_row),
    .sample_o   (row_sample),
    .scan_o     (scan_o)
  );

  kbs_debounce u_deb (
    .clk      (clk),
    .rst      (rst),
    .sample_i (row_sample),
    .row_i    (scan_row),
    .ret_n_i  (ret_n_i),
    .shift_i  (shift_i),
    .ctrl_i   (ctrl_i),
    .push_o   (key_push),
    .code_o   (key_code)
  );

  kbs_key_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push_i    (key_push),
    .din_i     (key_code),
    .rd_i      (rd_stb_i),
    .ovr_clr_i (ovr_clr_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .ovr_o     (overrun_o),
    .count_o   (fifo_cnt)
  );
endmodule

// File: rtl/kbs_keyscan_chk.sv
module kbs_keyscan_chk
  import kbs_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       mode,
  input logic [SCAN_W-1:0]          scan,
  input logic                       rd_stb,
  input logic [CODE_W-1:0]          rd_data,
  input logic                       irq,
  input logic                       ovr,
  input logic                       ovr_clr,
  input logic                       push,
  input logic [$clog2(DEPTH+1)-1:0] cnt
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  a_r2_decoded_onehot: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode)) |-> $onehot(scan));

  a_r2_encoded_range: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode)) |-> (scan[SCAN_W-1] == 1'b0));

  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  a_r8_empty_read_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && cnt == '0) |=> $stable(rd_data));

  a_r9_irq_drop: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !irq);

  a_r9_irq_empty: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> !irq);

  a_r9_irq_pending: assert property (@(posedge clk) disable iff (rst)
    (!$past(rd_stb) && cnt != '0) |-> irq);

  a_r10_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (push && cnt == CNT_W'(DEPTH)) |=> ovr);

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr && !ovr_clr) |=> ovr);
endmodule

bind kbs_keyscan kbs_keyscan_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode    (scan_decoded_i),
  .scan    (scan_o),
  .rd_stb  (rd_stb_i),
  .rd_data (rd_data_o),
  .irq     (irq_o),
  .ovr     (overrun_o),
  .ovr_clr (ovr_clr_i),
  .push    (key_push),
  .cnt     (fifo_cnt)
);

// File: tb/sim_kbs_keyscan.sv
`timescale 1ns/1ps
module sim_kbs_keyscan;
  localparam int STEP      = 12;
  localparam int DEPTH     = 8;
  localparam int SCAN_CLKS = 8 * STEP;

  logic       clk = 1'b0, rst = 1'b1, mode = 1'b0;
  logic       shift = 1'b0, ctrl = 1'b0, rd = 1'b0, oclr = 1'b0;
  logic [7:0] ret_n;
  logic [3:0] scan;
  logic [7:0] rdata;
  logic       irq, ovr;
  logic [63:0] pressed = '0;
  int         mrow;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  kbs_keyscan #(.STEP_CLKS(STEP), .FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .scan_decoded_i(mode), .ret_n_i(ret_n),
    .shift_i(shift), .ctrl_i(ctrl), .rd_stb_i(rd), .ovr_clr_i(oclr),
    .scan_o(scan), .rd_data_o(rdata), .irq_o(irq), .overrun_o(ovr)
  );

  // matrix model: columns of the row named by scan_o
  always_comb begin
    mrow = -1;
    if (!mode) mrow = int'(scan[2:0]);
    else case (scan)
      4'b0001: mrow = 0;
      4'b0010: mrow = 1;
      4'b0100: mrow = 2;
      4'b1000: mrow = 3;
      default: mrow = -1;
    endcase
    ret_n = '1;
    if (mrow >= 0)
      for (int c = 0; c < 8; c++) ret_n[c] = ~pressed[mrow*8 + c];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int code_of(input int k, input bit sh, input bit ct);
    return (int'(ct) << 7) | (int'(sh) << 6) | (k & 63);
  endfunction

  task automatic enter_key(input int k, input bit sh, input bit ct);
    shift = sh; ctrl = ct;
    pressed[k] = 1'b1;
    wait_clks(3 * SCAN_CLKS);
    pressed[k] = 1'b0;
    wait_clks(2 * SCAN_CLKS);
  endtask

  task automatic read_entry(output int code, output bit irq_low, output bit irq_after);
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    code    = int'(rdata);
    irq_low = irq;
    @(negedge clk) irq_after = irq;
  endtask

  task automatic scan_steps(input bit dec, input int n);
    logic [3:0] prev, exp;
    int dwell;
    prev = scan;
    while (scan == prev) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      prev  = scan;
      dwell = 0;
      while (scan == prev) begin @(negedge clk); dwell++; end
      exp = dec ? {prev[2:0], prev[3]} : {1'b0, prev[2:0] + 3'd1};
      check(dwell == STEP, "R1 dwell", dwell, STEP);
      check(scan == exp, "R1 R2 next position", int'(scan), int'(exp));
      if (dec) check($countones(scan) == 1, "R2 one-hot", int'(scan), 1);
      else     check(scan[3] == 1'b0, "R2 binary range", int'(scan), int'(scan[2:0]));
    end
  endtask

  initial begin
    int code, exp;
    bit il, ia;
    int seq [4];
    logic [7:0] held;

    wait_clks(4);
    check(irq == 1'b0,   "R11 irq", int'(irq), 0);
    check(ovr == 1'b0,   "R11 overrun", int'(ovr), 0);
    check(rdata == 8'd0, "R11 rd_data", int'(rdata), 0);
    check(scan == 4'd0,  "R11 scan", int'(scan), 0);
    rst = 1'b0;

    scan_steps(1'b0, 10);
    mode = 1'b1;
    wait_clks(2 * STEP);
    scan_steps(1'b1, 6);
    mode = 1'b0;
    wait_clks(SCAN_CLKS);

    // every key once, shift/ctrl patterns rotate with key number
    for (int k = 0; k < 64; k++) begin
      enter_key(k, k[0], k[1]);
      check(irq == 1'b1, "R9 pending", int'(irq), 1);
      read_entry(code, il, ia);
      exp = code_of(k, k[0], k[1]);
      check(code == exp, "R6 R3 key code", code, exp);
      check(il == 1'b0, "R9 drop after read", int'(il), 0);
      check(ia == 1'b0, "R5 single entry", int'(ia), 0);
    end

    // short press seen on at most one pass
    pressed[27] = 1'b1;
    wait_clks(6 * STEP);
    pressed[27] = 1'b0;
    wait_clks(3 * SCAN_CLKS);
    check(irq == 1'b0, "R4 short press rejected", int'(irq), 0);
    held = rdata;
    read_entry(code, il, ia);
    check(code == int'(held), "R8 empty read holds data", code, int'(held));
    check(ia == 1'b0, "R8 empty read irq", int'(ia), 0);

    // long hold, then re-press after release
    shift = 1'b1; ctrl = 1'b0;
    pressed[20] = 1'b1;
    wait_clks(8 * SCAN_CLKS);
    pressed[20] = 1'b0;
    wait_clks(2 * SCAN_CLKS);
    read_entry(code, il, ia);
    check(code == code_of(20, 1, 0), "R5 held key code", code, code_of(20, 1, 0));
    check(ia == 1'b0, "R5 held key once", int'(ia), 0);
    enter_key(20, 0, 1);
    read_entry(code, il, ia);
    check(code == code_of(20, 0, 1), "R5 re-entry after release", code, code_of(20, 0, 1));

    // ordering with irq reassertion
    seq[0] = 5; seq[1] = 40; seq[2] = 63; seq[3] = 12;
    for (int i = 0; i < 4; i++) enter_key(seq[i], i[0], i[1]);
    for (int i = 0; i < 4; i++) begin
      read_entry(code, il, ia);
      exp = code_of(seq[i], i[0], i[1]);
      check(code == exp, "R7 order", code, exp);
      check(il == 1'b0, "R9 drop", int'(il), 0);
      check(ia == (i < 3), "R9 reassert", int'(ia), int'(i < 3));
    end

    // fill to depth, then one more
    for (int i = 0; i < 8; i++) enter_key(i * 7, 0, 0);
    check(ovr == 1'b0, "R10 full without overrun", int'(ovr), 0);
    enter_key(56, 0, 0);
    check(ovr == 1'b1, "R10 overrun on ninth", int'(ovr), 1);
    for (int i = 0; i < 8; i++) begin
      read_entry(code, il, ia);
      check(code == code_of(i * 7, 0, 0), "R10 R7 kept entries", code, code_of(i * 7, 0, 0));
    end
    check(ia == 1'b0, "R10 ninth dropped", int'(ia), 0);
    read_entry(code, il, ia);
    check(code == code_of(49, 0, 0), "R8 empty read after drain", code, code_of(49, 0, 0));
    check(ovr == 1'b1, "R10 sticky", int'(ovr), 1);
    @(negedge clk) oclr = 1'b1;
    @(negedge clk) oclr = 1'b0;
    check(ovr == 1'b0, "R10 cleared", int'(ovr), 0);

    // one-of-four mode keys
    mode = 1'b1;
    wait_clks(SCAN_CLKS);
    enter_key(21, 1, 1);
    enter_key(30, 0, 0);
    enter_key(1, 1, 0);
    read_entry(code, il, ia);
    check(code == code_of(21, 1, 1), "R2 R3 decoded row 2", code, code_of(21, 1, 1));
    read_entry(code, il, ia);
    check(code == code_of(30, 0, 0), "R2 R3 decoded row 3", code, code_of(30, 0, 0));
    read_entry(code, il, ia);
    check(code == code_of(1, 1, 0), "R2 R3 decoded row 0", code, code_of(1, 1, 0));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule